// File: doc/BRIEF.md
# Timer Output Routing Matrix with Pattern Override

This block sits behind the compare stage of a PWM timer. It takes the compare-channel waveforms and spreads them over a wider set of output pins. A 2-bit routing mode picks one of four fixed channel-to-pin maps. The maps let a small number of channels drive full bridges, stepper phases or many LED strings.

A pattern overlay follows the routing stage. Each pin has an enable bit and a level bit. When the enable bit is set, the pin carries the level bit and not its routed channel. Software writes the pattern into a staging copy, and the timer's UPDATE strobe copies the staging copy into the live pattern. This keeps commutation steps aligned to PWM period boundaries. A direct write bypasses the staging step and changes the live pattern at once.

The pins are registered, so the pin pads see a glitch-free level one clock after any input change.

Top module: `pwm_pin_router`

## Requirements
- R1: While `rst` is high, `pin_out` is all zeros, the routing mode returns to 0, and both pattern fields (live and staged) are cleared.
- R2: In mode 0, pin k carries compare channel (k mod NUM_CH). With the defaults, pins 6 and 7 repeat channels 0 and 1.
- R3: In mode 1, pin k carries channel (k mod H), where H = NUM_CH/2 rounded down, with a minimum of 1. With the defaults H = 3.
- R4: In mode 2, every pin carries compare channel 0.
- R5: In mode 3, pin 0 carries channel 0 and every other pin carries channel 1.
- R6: The pattern word has two fields. Bits [NUM_OUT-1:0] are per-pin enables and bits [2*NUM_OUT-1:NUM_OUT] are per-pin levels. A pin whose live enable bit is 1 outputs its live level bit, whatever its routed channel is.
- R7: A write with `pat_wr`=1 and `pat_direct`=0 loads only the staging copy. The pins do not change until an UPDATE occurs.
- R8: A `tmr_update` pulse copies the staging copy into the live pattern. If a staged write arrives in the same cycle, the live pattern takes the staging value held before that write.
- R9: A write with `pat_wr`=1 and `pat_direct`=1 loads the live pattern and the staging copy in the same cycle, so a later UPDATE does not undo it.
- R10: When a direct write and `tmr_update` occur in the same cycle, the live pattern takes the direct-write data.
- R11: `pin_out` is registered. A change on `cc_wave` reaches the pins at the next rising clock edge and not before.
- R12: A `mode_wr` pulse loads `mode_wdata` into the routing mode at the next clock edge. Pins reflect the new mode at the edge after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cc_wave | input | NUM_CH | Compare-channel waveform levels |
| mode_wr | input | 1 | Load strobe for the routing mode |
| mode_wdata | input | 2 | New routing mode (0..3) |
| pat_wr | input | 1 | Pattern write strobe |
| pat_direct | input | 1 | 1: write the live pattern (and the staging copy); 0: write the staging copy only |
| pat_wdata | input | 2*NUM_OUT | Pattern data: levels in the upper half, enables in the lower half |
| tmr_update | input | 1 | Timer UPDATE event that commits the staging copy |
| pin_out | output | NUM_OUT | Registered pin levels |

## Verification
The bound checker checks the following on every cycle:
- the reset value of the pins;
- the mode register load;
- that the live pattern holds between commits, takes the staging copy on UPDATE, and takes the data on a direct write;
- that forced pins show their level bit;
- that mode 2 broadcasts channel 0.

The exact maps of modes 0, 1 and 3 are shown only by the bench's vector table. The same applies to these sequence cases:
- that a staged write does not reach the pins;
- the same-cycle write/UPDATE orderings;
- the one-cycle pin latency.

// File: rtl/pwm_route_pkg.sv
package pwm_route_pkg;

    localparam int unsigned DEF_NUM_CH  = 6;
    localparam int unsigned DEF_NUM_OUT = 8;

    typedef enum logic [1:0] {
        ROUTE_MODULO = 2'd0,
        ROUTE_HALF   = 2'd1,
        ROUTE_ALL0   = 2'd2,
        ROUTE_SPLIT  = 2'd3
    } route_mode_e;

    // Channel count used by the half-modulo map: floor(nch/2), at least 1.
    function automatic int unsigned half_count(int unsigned nch);
        int unsigned h;
        h = nch / 2;
        if (h < 1) h = 1;
        return h;
    endfunction

    // Source channel for output k under a given map.
    function automatic int unsigned src_chan(logic [1:0] mode, int unsigned k,
                                             int unsigned nch);
        int unsigned idx;
        case (mode)
            2'd0:    idx = k % nch;
            2'd1:    idx = k % half_count(nch);
            2'd2:    idx = 0;
            default: idx = (k == 0 || nch < 2) ? 0 : 1;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/route_matrix.sv
module route_matrix
    import pwm_route_pkg::*;
#(
    parameter int unsigned NUM_CH  = DEF_NUM_CH,
    parameter int unsigned NUM_OUT = DEF_NUM_OUT
) (
    input  logic [NUM_CH-1:0]  cc_wave,
    input  route_mode_e        mode,
    output logic [NUM_OUT-1:0] routed
);

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        localparam int unsigned IDX_MOD   = src_chan(2'd0, k, NUM_CH);
        localparam int unsigned IDX_HALF  = src_chan(2'd1, k, NUM_CH);
        localparam int unsigned IDX_ALL0  = src_chan(2'd2, k, NUM_CH);
        localparam int unsigned IDX_SPLIT = src_chan(2'd3, k, NUM_CH);

        always_comb begin
            case (mode)
                ROUTE_MODULO: routed[k] = cc_wave[IDX_MOD];
                ROUTE_HALF:   routed[k] = cc_wave[IDX_HALF];
                ROUTE_ALL0:   routed[k] = cc_wave[IDX_ALL0];
                default:      routed[k] = cc_wave[IDX_SPLIT];
            endcase
        end
    end

endmodule

// File: rtl/pattern_bank.sv
module pattern_bank #(
    parameter int unsigned NUM_OUT = 8,
    localparam int unsigned PW = 2 * NUM_OUT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_direct,
    input  logic [PW-1:0]      wr_data,
    input  logic               commit,
    output logic [NUM_OUT-1:0] live_level,
    output logic [NUM_OUT-1:0] live_enable,
    output logic [PW-1:0]      staged
);

    typedef struct packed {
        logic [NUM_OUT-1:0] level;
        logic [NUM_OUT-1:0] enable;
    } pat_t;

    pat_t stage_q, live_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            live_q  <= '0;
        end else begin
            if (wr_en) stage_q <= pat_t'(wr_data);
            if (wr_en && wr_direct) live_q <= pat_t'(wr_data);
            else if (commit)        live_q <= stage_q;
        end
    end

    assign live_level  = live_q.level;
    assign live_enable = live_q.enable;
    assign staged      = stage_q;

endmodule

// File: rtl/pattern_overlay.sv
module pattern_overlay #(
    parameter int unsigned NUM_OUT = 8
) (
    input  logic [NUM_OUT-1:0] routed,
    input  logic [NUM_OUT-1:0] level,
    input  logic [NUM_OUT-1:0] enable,
    output logic [NUM_OUT-1:0] pins
);

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_pin
        assign pins[k] = enable[k] ? level[k] : routed[k];
    end

endmodule

// File: rtl/pwm_pin_router.sv
module pwm_pin_router
    import pwm_route_pkg::*;
#(
    parameter int unsigned NUM_CH  = DEF_NUM_CH,
    parameter int unsigned NUM_OUT = DEF_NUM_OUT,
    localparam int unsigned PW = 2 * NUM_OUT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CH-1:0]  cc_wave,
    input  logic               mode_wr,
    input  logic [1:0]         mode_wdata,
    input  logic               pat_wr,
    input  logic               pat_direct,
    input  logic [PW-1:0]      pat_wdata,
    input  logic               tmr_update,
    output logic [NUM_OUT-1:0] pin_out
);

    route_mode_e        mode_q;
    logic [NUM_OUT-1:0] routed;
    logic [NUM_OUT-1:0] live_level;
    logic [NUM_OUT-1:0] live_enable;
    logic [PW-1:0]      staged;
    logic [NUM_OUT-1:0] pins_d;

    always_ff @(posedge clk) begin
        if (rst)          mode_q <= ROUTE_MODULO;
        else if (mode_wr) mode_q <= route_mode_e'(mode_wdata);
    end

    route_matrix #(.NUM_CH(NUM_CH), .NUM_OUT(NUM_OUT)) u_matrix (
        .cc_wave (cc_wave),
        .mode    (mode_q),
        .routed  (routed)
    );

    pattern_bank #(.NUM_OUT(NUM_OUT)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (pat_wr),
        .wr_direct   (pat_direct),
        .wr_data     (pat_wdata),
        .commit      (tmr_update),
        .live_level  (live_level),
        .live_enable (live_enable),
        .staged      (staged)
    );

    pattern_overlay #(.NUM_OUT(NUM_OUT)) u_overlay (
        .routed (routed),
        .level  (live_level),
        .enable (live_enable),
        .pins   (pins_d)
    );

    always_ff @(posedge clk) begin
        if (rst) pin_out <= '0;
        else     pin_out <= pins_d;
    end

endmodule

// File: rtl/pwm_pin_router_chk.sv
module pwm_pin_router_chk #(
    parameter int unsigned NUM_CH  = 6,
    parameter int unsigned NUM_OUT = 8,
    localparam int unsigned PW = 2 * NUM_OUT
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_CH-1:0]  cc_wave,
    input logic               mode_wr,
    input logic [1:0]         mode_wdata,
    input logic               pat_wr,
    input logic               pat_direct,
    input logic [PW-1:0]      pat_wdata,
    input logic               tmr_update,
    input logic [NUM_OUT-1:0] pin_out,
    input logic [1:0]         mode_q,
    input logic [NUM_OUT-1:0] live_level,
    input logic [NUM_OUT-1:0] live_enable,
    input logic [PW-1:0]      staged
);

    logic [PW-1:0] live_word;
    assign live_word = {live_level, live_enable};

    assert_reset_pins_R1: assert property (@(posedge clk)
        rst |=> (pin_out == '0));

    assert_mode_load_R12: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> (mode_q == $past(mode_wdata)));

    assert_broadcast_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd2 && live_enable == '0 && !mode_wr)
            |=> (pin_out == {NUM_OUT{$past(cc_wave[0])}}));

    assert_forced_level_R6: assert property (@(posedge clk) disable iff (rst)
        (live_enable != '0)
            |=> ((pin_out & $past(live_enable)) == ($past(live_level) & $past(live_enable))));

    assert_live_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!(pat_wr && pat_direct) && !tmr_update) |=> $stable(live_word));

    assert_commit_R8: assert property (@(posedge clk) disable iff (rst)
        (tmr_update && !(pat_wr && pat_direct)) |=> (live_word == $past(staged)));

    assert_direct_R9: assert property (@(posedge clk) disable iff (rst)
        (pat_wr && pat_direct) |=> (live_word == $past(pat_wdata) && staged == $past(pat_wdata)));

endmodule

bind pwm_pin_router pwm_pin_router_chk #(.NUM_CH(NUM_CH), .NUM_OUT(NUM_OUT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cc_wave     (cc_wave),
    .mode_wr     (mode_wr),
    .mode_wdata  (mode_wdata),
    .pat_wr      (pat_wr),
    .pat_direct  (pat_direct),
    .pat_wdata   (pat_wdata),
    .tmr_update  (tmr_update),
    .pin_out     (pin_out),
    .mode_q      (mode_q),
    .live_level  (live_level),
    .live_enable (live_enable),
    .staged      (staged)
);

// File: tb/tb_pwm_pin_router.sv
module tb_pwm_pin_router;

    localparam int unsigned NCH  = 6;
    localparam int unsigned NOUT = 8;
    localparam int unsigned NVEC = 12;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NCH-1:0]  cc_wave = '0;
    logic            mode_wr = 1'b0;
    logic [1:0]      mode_wdata = '0;
    logic            pat_wr = 1'b0;
    logic            pat_direct = 1'b0;
    logic [15:0]     pat_wdata = '0;
    logic            tmr_update = 1'b0;
    logic [NOUT-1:0] pin_out;

    int n_total = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    pwm_pin_router #(.NUM_CH(NCH), .NUM_OUT(NOUT)) dut (
        .clk(clk), .rst(rst), .cc_wave(cc_wave),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .pat_wr(pat_wr), .pat_direct(pat_direct), .pat_wdata(pat_wdata),
        .tmr_update(tmr_update), .pin_out(pin_out)
    );

    // {mode[1:0], cc[5:0], expected pins[7:0]}
    localparam logic [15:0] VEC [NVEC] = '{
        {2'd0, 6'b000001, 8'h41},
        {2'd0, 6'b100010, 8'hA2},
        {2'd0, 6'b111111, 8'hFF},
        {2'd1, 6'b000001, 8'h49},
        {2'd1, 6'b111100, 8'h24},
        {2'd1, 6'b000010, 8'h92},
        {2'd2, 6'b000001, 8'hFF},
        {2'd2, 6'b111110, 8'h00},
        {2'd3, 6'b000010, 8'hFE},
        {2'd3, 6'b000001, 8'h01},
        {2'd3, 6'b000011, 8'hFF},
        {2'd0, 6'b010000, 8'h10}
    };

    task automatic chk(input string tag, input logic [NOUT-1:0] act,
                       input logic [NOUT-1:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode_wr = 1'b1; mode_wdata = m;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic write_pat(input logic direct, input logic upd,
                             input logic [7:0] lvl, input logic [7:0] en);
        @(negedge clk);
        pat_wr = 1'b1; pat_direct = direct; pat_wdata = {lvl, en};
        tmr_update = upd;
        @(negedge clk);
        pat_wr = 1'b0; pat_direct = 1'b0; tmr_update = 1'b0;
    endtask

    task automatic pulse_update();
        @(negedge clk);
        tmr_update = 1'b1;
        @(negedge clk);
        tmr_update = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        // R1: reset state
        cc_wave = 6'b000011;
        repeat (3) @(negedge clk);
        chk("R1 pins during reset", pin_out, 8'h00);
        rst = 1'b0;
        settle();
        chk("R1 mode 0 and empty pattern after reset", pin_out, 8'hC3);

        // Vector table: R2..R5 routing maps
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] m;
            m = VEC[i][15:14];
            set_mode(m);
            cc_wave = VEC[i][13:8];
            settle();
            case (m)
                2'd0: chk($sformatf("R2 vec %0d", i), pin_out, VEC[i][7:0]);
                2'd1: chk($sformatf("R3 vec %0d", i), pin_out, VEC[i][7:0]);
                2'd2: chk($sformatf("R4 vec %0d", i), pin_out, VEC[i][7:0]);
                default: chk($sformatf("R5 vec %0d", i), pin_out, VEC[i][7:0]);
            endcase
        end

        // R11: output latency
        set_mode(2'd2);
        cc_wave = 6'b000000;
        settle();
        chk("R11 baseline", pin_out, 8'h00);
        cc_wave = 6'b000001;
        #1;
        chk("R11 no change before edge", pin_out, 8'h00);
        settle();
        chk("R11 change after edge", pin_out, 8'hFF);

        // R12: mode load timing
        @(negedge clk);
        mode_wr = 1'b1; mode_wdata = 2'd3; cc_wave = 6'b000010;
        @(negedge clk);
        mode_wr = 1'b0;
        chk("R12 old mode still on pins", pin_out, 8'h00);
        settle();
        chk("R12 new mode on pins", pin_out, 8'hFE);

        // R7/R8/R6: staged write, then commit
        set_mode(2'd2);
        cc_wave = 6'b000000;
        write_pat(1'b0, 1'b0, 8'hFF, 8'h0F);
        settle();
        chk("R7 staged write not visible", pin_out, 8'h00);
        pulse_update();
        settle();
        chk("R8 commit forces low nibble high", pin_out, 8'h0F);

        cc_wave = 6'b000001;
        write_pat(1'b0, 1'b0, 8'h00, 8'hF0);
        settle();
        chk("R6 forced ones plus routed ones", pin_out, 8'hFF);
        pulse_update();
        settle();
        chk("R6 forced zeros on high nibble", pin_out, 8'h0F);

        // R8: staged write in the same cycle as UPDATE
        write_pat(1'b0, 1'b1, 8'h00, 8'hFF);
        settle();
        chk("R8 same-cycle commit takes old staging", pin_out, 8'h0F);
        pulse_update();
        settle();
        chk("R8 next commit takes new staging", pin_out, 8'h00);

        // R9: direct write
        write_pat(1'b1, 1'b0, 8'hAA, 8'hFF);
        settle();
        chk("R9 direct write immediate", pin_out, 8'hAA);
        pulse_update();
        settle();
        chk("R9 later commit keeps direct value", pin_out, 8'hAA);

        // R10: direct write vs UPDATE in the same cycle
        write_pat(1'b0, 1'b0, 8'h00, 8'hFF);
        write_pat(1'b1, 1'b1, 8'h55, 8'hFF);
        settle();
        chk("R10 direct wins over commit", pin_out, 8'h55);
        pulse_update();
        settle();
        chk("R10 staging holds direct data", pin_out, 8'h55);

        // R1: reset clears pattern and mode
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 pins in second reset", pin_out, 8'h00);
        rst = 1'b0;
        cc_wave = 6'b100010;
        settle();
        chk("R1 pattern and mode cleared", pin_out, 8'hA2);
        pulse_update();
        settle();
        chk("R1 staging cleared", pin_out, 8'hA2);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule